// File: doc/BRIEF.md
# Receive Link Bring-Up Sequencer

This block orders the start-up of a source-synchronous high-speed receive path. After a synchronous reset or a user restart request it drives the clock synthesizer's reset for a minimum time, then waits until the synthesizer's lock input has been high without a break for a set number of cycles. Only then does it release the reset of the dynamic phase alignment circuit, so that alignment cannot settle on a phase tap chosen while the clock was still moving.

Once the alignment circuit reports lock, the sequencer pulses the reset of the clock-domain-crossing FIFO for a set number of cycles and then raises a registered ready flag. The FIFO is never reset before alignment lock, because a FIFO held in reset feeds no transitions to the alignment logic and lock would never come. The alignment lock input is treated as sticky: it is looked at only while waiting for it. A loss of clock lock after the clock wait sends the whole sequence back to its start. If alignment lock does not arrive in time, an error flag is set and the sequence starts again.

Top module: `rx_link_bringup`

## Requirements
- R1: After `rst` or a `start_req` pulse, `pll_rst` is high for exactly HOLD cycles, HOLD = ceil(PLL_RST_MIN_PS / CLK_PERIOD_PS) with a minimum of 1 (2 cycles at 5000 ps and 10000 ps).
- R2: After `pll_rst` falls, `align_rst` falls on the clock edge after the one at which `pll_locked` has been sampled high on LOCK_STABLE_CYCLES consecutive edges; with lock present from the first cycle after `pll_rst` falls, this is LOCK_STABLE_CYCLES+1 cycles after `pll_rst` falls.
- R3: `align_rst` stays high while the clock lock is not yet stable; a single low sample of `pll_locked` during the wait restarts the stability count from zero.
- R4: `fifo_rst` rises only on the edge after `align_locked` is sampled high with `align_rst` low; it is never high while the sequencer waits for alignment lock.
- R5: `fifo_rst` stays high for exactly FIFO_RST_CYCLES cycles, and `link_ready` rises on the edge at which `fifo_rst` falls.
- R6: `link_ready` is a register that is high only in the operating state; while it is high, `pll_rst`, `align_rst` and `fifo_rst` are all low.
- R7: If `pll_locked` is sampled low while the sequencer waits for alignment lock, resets the FIFO or is operating, then on the next cycle `pll_rst` and `align_rst` are high and `fifo_rst` and `link_ready` are low, and the sequence restarts.
- R8: If `align_locked` is not sampled high within ALIGN_TIMEOUT_CYCLES cycles after `align_rst` falls, `align_timeout` is set and `pll_rst` rises together with it, exactly ALIGN_TIMEOUT_CYCLES cycles after `align_rst` fell; alignment lock sampled on the last edge of that window wins over the timeout.
- R9: `align_timeout` stays high until `rst` or `start_req`, even after a later retry succeeds; `start_req` clears it on the same edge that restarts the sequence.
- R10: A drop of `align_locked` while `link_ready` is high has no effect: `link_ready` stays high and all three resets stay low.
- R11: While `rst` is high and on the cycle after it, `pll_rst` and `align_rst` are high and `fifo_rst`, `link_ready` and `align_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to restart the bring-up |
| pll_locked | input | 1 | Lock indication from the clock synthesizer |
| align_locked | input | 1 | Lock indication from the phase alignment circuit (sticky) |
| pll_rst | output | 1 | Reset to the clock synthesizer |
| align_rst | output | 1 | Reset to the phase alignment circuit |
| fifo_rst | output | 1 | Reset pulse to the clock-domain-crossing FIFO |
| link_ready | output | 1 | Receive path is ready for data |
| align_timeout | output | 1 | Sticky flag: alignment lock timed out at least once |

## Verification
The alignment-lock check and the timeout check can fall on the same clock edge, when lock arrives in the last cycle of the wait window. A vector sets the alignment lock delay to ALIGN_TIMEOUT_CYCLES-1 after the alignment reset is released, so the lock is sampled on exactly the edge where the window ends. The design must take the lock: `fifo_rst` must rise ALIGN_TIMEOUT_CYCLES cycles after `align_rst` fell, `align_timeout` must stay low, and the neighbouring vector, one cycle later, must instead raise the flag and restart.

// File: rtl/rx_link_bringup_pkg.sv
package rx_link_bringup_pkg;

  typedef enum logic [2:0] {
    ST_CLK_RESET  = 3'd0,
    ST_CLK_SETTLE = 3'd1,
    ST_ALIGN_WAIT = 3'd2,
    ST_FIFO_FLUSH = 3'd3,
    ST_RUN        = 3'd4
  } seq_state_e;

  function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lock_stability_filter.sv
// Counts consecutive high samples of a lock input; any low sample or a clear
// restarts the count. Reports stable once the run reaches RUN_CYCLES.
module lock_stability_filter #(
  parameter int unsigned RUN_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic lock_in,
  output logic stable
);
  localparam int unsigned CW = $clog2(RUN_CYCLES + 1);
  localparam logic [CW-1:0] TARGET = CW'(RUN_CYCLES);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !lock_in) begin
      run_q <= '0;
    end else if (run_q != TARGET) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign stable = (run_q == TARGET);

endmodule

// File: rtl/seq_interval_timer.sv
// Shared up-counter that measures time spent in the current state.
module seq_interval_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [TW-1:0] elapsed
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      elapsed <= '0;
    end else if (elapsed != {TW{1'b1}}) begin
      elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/bringup_ctrl_fsm.sv
// Ordering state machine with registered outputs.
module bringup_ctrl_fsm
  import rx_link_bringup_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES    = 2,
  parameter int unsigned FLUSH_CYCLES   = 4,
  parameter int unsigned TIMEOUT_CYCLES = 65536,
  parameter int unsigned TW             = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          pll_locked,
  input  logic          lock_stable,
  input  logic          align_locked,
  input  logic [TW-1:0] elapsed,
  output logic          tmr_clr,
  output logic          pll_rst,
  output logic          align_rst,
  output logic          fifo_rst,
  output logic          link_ready,
  output logic          align_timeout
);
  localparam logic [TW-1:0] HOLD_LAST    = TW'(HOLD_CYCLES - 1);
  localparam logic [TW-1:0] FLUSH_LAST   = TW'(FLUSH_CYCLES - 1);
  localparam logic [TW-1:0] TIMEOUT_LAST = TW'(TIMEOUT_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic       expire;

  always_comb begin
    state_d = state_q;
    expire  = 1'b0;
    if (start_req) begin
      state_d = ST_CLK_RESET;
    end else begin
      unique case (state_q)
        ST_CLK_RESET: begin
          if (elapsed == HOLD_LAST) state_d = ST_CLK_SETTLE;
        end
        ST_CLK_SETTLE: begin
          if (lock_stable) state_d = ST_ALIGN_WAIT;
        end
        ST_ALIGN_WAIT: begin
          // lock loss first, then alignment lock, then the window limit
          if (!pll_locked) begin
            state_d = ST_CLK_RESET;
          end else if (align_locked) begin
            state_d = ST_FIFO_FLUSH;
          end else if (elapsed == TIMEOUT_LAST) begin
            state_d = ST_CLK_RESET;
            expire  = 1'b1;
          end
        end
        ST_FIFO_FLUSH: begin
          if (!pll_locked) begin
            state_d = ST_CLK_RESET;
          end else if (elapsed == FLUSH_LAST) begin
            state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (!pll_locked) state_d = ST_CLK_RESET;
        end
        default: state_d = ST_CLK_RESET;
      endcase
    end
  end

  assign tmr_clr = start_req || (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_CLK_RESET;
      pll_rst       <= 1'b1;
      align_rst     <= 1'b1;
      fifo_rst      <= 1'b0;
      link_ready    <= 1'b0;
      align_timeout <= 1'b0;
    end else begin
      state_q    <= state_d;
      pll_rst    <= (state_d == ST_CLK_RESET);
      align_rst  <= (state_d == ST_CLK_RESET) || (state_d == ST_CLK_SETTLE);
      fifo_rst   <= (state_d == ST_FIFO_FLUSH);
      link_ready <= (state_d == ST_RUN);
      if (start_req) begin
        align_timeout <= 1'b0;
      end else if (expire) begin
        align_timeout <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_link_bringup.sv
module rx_link_bringup
  import rx_link_bringup_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS        = 5000,
  parameter int unsigned PLL_RST_MIN_PS       = 10000,
  parameter int unsigned LOCK_STABLE_CYCLES   = 1024,
  parameter int unsigned FIFO_RST_CYCLES      = 4,
  parameter int unsigned ALIGN_TIMEOUT_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic pll_locked,
  input  logic align_locked,
  output logic pll_rst,
  output logic align_rst,
  output logic fifo_rst,
  output logic link_ready,
  output logic align_timeout
);
  localparam int unsigned RAW_HOLD       = div_ceil(PLL_RST_MIN_PS, CLK_PERIOD_PS);
  localparam int unsigned PLL_RST_CYCLES = (RAW_HOLD < 1) ? 1 : RAW_HOLD;
  localparam int unsigned LONGEST        = max3(PLL_RST_CYCLES, FIFO_RST_CYCLES,
                                                ALIGN_TIMEOUT_CYCLES);
  localparam int unsigned TW             = $clog2(LONGEST + 1);

  logic          lock_stable;
  logic          tmr_clr;
  logic [TW-1:0] elapsed;

  generate
    if (LOCK_STABLE_CYCLES == 0) begin : g_no_filter
      assign lock_stable = pll_locked && !pll_rst;
    end else begin : g_filter
      lock_stability_filter #(
        .RUN_CYCLES(LOCK_STABLE_CYCLES)
      ) u_filter (
        .clk    (clk),
        .rst    (rst),
        .clr    (pll_rst),
        .lock_in(pll_locked),
        .stable (lock_stable)
      );
    end
  endgenerate

  seq_interval_timer #(
    .TW(TW)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (tmr_clr),
    .elapsed(elapsed)
  );

  bringup_ctrl_fsm #(
    .HOLD_CYCLES   (PLL_RST_CYCLES),
    .FLUSH_CYCLES  (FIFO_RST_CYCLES),
    .TIMEOUT_CYCLES(ALIGN_TIMEOUT_CYCLES),
    .TW            (TW)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_req    (start_req),
    .pll_locked   (pll_locked),
    .lock_stable  (lock_stable),
    .align_locked (align_locked),
    .elapsed      (elapsed),
    .tmr_clr      (tmr_clr),
    .pll_rst      (pll_rst),
    .align_rst    (align_rst),
    .fifo_rst     (fifo_rst),
    .link_ready   (link_ready),
    .align_timeout(align_timeout)
  );

endmodule

// File: rtl/rx_link_bringup_chk.sv
module rx_link_bringup_chk #(
  parameter int unsigned HOLD_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic start_req,
  input logic pll_locked,
  input logic align_locked,
  input logic pll_rst,
  input logic align_rst,
  input logic fifo_rst,
  input logic link_ready,
  input logic align_timeout
);
  localparam int unsigned RW = $clog2(HOLD_CYCLES + 1) + 1;
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !pll_rst) begin
      run_len <= '0;
    end else if (run_len != RMAX) begin
      run_len <= run_len + 1'b1;
    end
  end

  // R1
  pll_rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_rst) |-> (run_len >= RW'(HOLD_CYCLES)));

  // R3
  align_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pll_locked) |-> align_rst);

  // R4
  fifo_after_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_rst) |-> ($past(align_locked) && !align_rst));

  // R5
  ready_after_fifo_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_ready) |-> ($past(fifo_rst) && !fifo_rst));

  // R6
  ready_clean_chk: assert property (@(posedge clk) disable iff (rst)
    link_ready |-> (!pll_rst && !align_rst && !fifo_rst));

  // R6
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({pll_rst, fifo_rst, link_ready}) <= 1);

  // R7
  lock_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (link_ready && !pll_locked && !start_req) |=> (pll_rst && !link_ready));

  // R8
  timeout_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(align_timeout) |-> pll_rst);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (align_timeout && !start_req) |=> align_timeout);

endmodule

bind rx_link_bringup rx_link_bringup_chk #(
  .HOLD_CYCLES(PLL_RST_CYCLES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_req    (start_req),
  .pll_locked   (pll_locked),
  .align_locked (align_locked),
  .pll_rst      (pll_rst),
  .align_rst    (align_rst),
  .fifo_rst     (fifo_rst),
  .link_ready   (link_ready),
  .align_timeout(align_timeout)
);

// File: tb/rx_link_bringup_tb.sv
`timescale 1ns/1ps
module rx_link_bringup_tb;
  localparam int LS   = 16;
  localparam int FP   = 4;
  localparam int TO   = 40;
  localparam int HOLD = 2;
  localparam int NV   = 5;
  // {pll lock delay, align lock delay, expect ready}
  localparam logic [16:0] VEC [NV] = '{
    {8'd0, 8'd0,      1'b1},
    {8'd3, 8'd5,      1'b1},
    {8'd7, 8'(TO-1),  1'b1},
    {8'd0, 8'(TO),    1'b0},
    {8'd2, 8'd1,      1'b1}
  };

  logic clk = 1'b0;
  logic rst, start_req, pll_locked, align_locked;
  logic pll_rst, align_rst, fifo_rst, link_ready, align_timeout;
  int   nchk = 0, nfail = 0, cyc = 0;
  int   pcfg, acfg, pcnt, acnt;
  logic pkill, akill;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  rx_link_bringup #(
    .LOCK_STABLE_CYCLES  (LS),
    .FIFO_RST_CYCLES     (FP),
    .ALIGN_TIMEOUT_CYCLES(TO)
  ) u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .pll_locked(pll_locked),
    .align_locked(align_locked), .pll_rst(pll_rst), .align_rst(align_rst),
    .fifo_rst(fifo_rst), .link_ready(link_ready), .align_timeout(align_timeout)
  );

  // clock synthesizer model: locks pcfg cycles after its reset is released
  always @(negedge clk) begin
    if (pll_rst) begin
      pcnt = 0; pll_locked = 1'b0;
    end else if (pcnt >= pcfg) begin
      pll_locked = !pkill;
    end else begin
      pcnt++;
    end
  end

  // alignment model: sticky lock acfg cycles after its reset is released
  always @(negedge clk) begin
    if (align_rst) begin
      acnt = 0; align_locked = 1'b0;
    end else if (akill) begin
      align_locked = 1'b0;
    end else if (!align_locked) begin
      if (acnt == acfg) align_locked = 1'b1;
      else acnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!link_ready) @(negedge clk);
  endtask

  task automatic run_vec(input int pd, input int ad, input bit ok);
    int t_pf, t_af, t_fr, w;
    bit saw_fifo;
    @(posedge clk); pcfg = pd; acfg = ad;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    check("R9 start clears flag", align_timeout, 0);
    w = 0;
    while (pll_rst) begin w++; @(negedge clk); end
    check("R1 pll_rst width", w, HOLD);
    t_pf = cyc;
    while (align_rst) @(negedge clk);
    t_af = cyc;
    check("R2 align release delay", t_af - t_pf, LS + 1 + pd);
    if (ok) begin
      while (!fifo_rst) @(negedge clk);
      t_fr = cyc;
      check("R4 fifo after align lock", t_fr - t_af, ad + 1);
      while (fifo_rst) @(negedge clk);
      check("R5 fifo pulse width", cyc - t_fr, FP);
      check("R5 ready at fifo fall", link_ready, 1);
      check("R8 no timeout on last-cycle lock", align_timeout, 0);
    end else begin
      saw_fifo = 1'b0;
      while (!pll_rst) begin saw_fifo |= fifo_rst; @(negedge clk); end
      check("R4 no fifo before align lock", saw_fifo, 0);
      check("R8 timeout restart delay", cyc - t_af, TO);
      check("R8 timeout flag", align_timeout, 1);
      @(posedge clk); acfg = 0;
      wait_ready();
      check("R9 flag sticky after retry", align_timeout, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int t_pf, t_af;
    rst = 1'b1; start_req = 1'b0; pcfg = 0; acfg = 0; pkill = 1'b0; akill = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset values
    check("R11 pll_rst in reset", pll_rst, 1);
    check("R11 align_rst in reset", align_rst, 1);
    check("R11 fifo_rst in reset", fifo_rst, 0);
    check("R11 ready in reset", link_ready, 0);
    check("R11 flag in reset", align_timeout, 0);
    rst = 1'b0;
    wait_ready();

    for (int i = 0; i < NV; i++) begin
      run_vec(int'(VEC[i][16:9]), int'(VEC[i][8:1]), VEC[i][0]);
    end

    // R3: one low lock sample during the stability window restarts the count
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    while (pll_rst) @(negedge clk);
    t_pf = cyc;
    repeat (5) @(negedge clk);
    @(posedge clk); pkill = 1'b1;
    @(posedge clk); pkill = 1'b0;
    while (align_rst) @(negedge clk);
    t_af = cyc;
    check("R3 glitch restarts stability count", t_af - t_pf, 5 + LS + 3);
    wait_ready();

    // R10: alignment lock drop while operating is ignored
    @(posedge clk); akill = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R10 ready kept", link_ready, 1);
      check("R10 resets stay low", {pll_rst, align_rst, fifo_rst}, 0);
    end
    @(posedge clk); akill = 1'b0;

    // R7: clock lock loss while operating
    @(posedge clk); pkill = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 pll_rst after loss", pll_rst, 1);
    check("R7 align_rst after loss", align_rst, 1);
    check("R7 ready dropped", link_ready, 0);
    check("R6 fifo_rst low after loss", fifo_rst, 0);
    @(posedge clk); pkill = 1'b0;
    wait_ready();
    check("R6 operating outputs", {pll_rst, align_rst, fifo_rst}, 0);

    // R7: clock lock loss while waiting for alignment
    @(posedge clk); acfg = 20;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    while (align_rst) @(negedge clk);
    repeat (3) @(negedge clk);
    @(posedge clk); pkill = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 restart from align wait", pll_rst, 1);
    check("R7 align_rst from align wait", align_rst, 1);
    check("R4 fifo_rst stays low", fifo_rst, 0);
    @(posedge clk); pkill = 1'b0; acfg = 0;
    wait_ready();

    // R11: reset while operating
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R11 mid-run pll_rst", pll_rst, 1);
    check("R11 mid-run align_rst", align_rst, 1);
    check("R11 mid-run ready", link_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 after release", {pll_rst, align_rst, fifo_rst, link_ready, align_timeout}, 5'b11000);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule